// File: doc/BRIEF.md
# Move-Instruction Source Operand Unit

This unit turns the 8-bit source byte of a move-only instruction into a 16-bit operand. The instruction set has no opcode field, so the prefix bits of that byte alone choose the operand kind. The kinds are a device read over a 7-bit device bus, a sign-extended 6-bit short constant, a register read, or a memory load. The memory load uses a register's contents as the address, with no offset added. Register reads and memory loads each have a variant that also adds one to the register after use.

A request starts with a one-cycle `start` pulse that carries `src_sel`. Register and immediate operands finish on a fixed schedule. Memory and device reads raise a request and hold it, with `stall` high, until the target acknowledges. The unit holds the sixteen-entry register file. An external write port lets the destination side of the machine update registers.

Top module: `mv_src_unit`

## Requirements
- R1: After reset `done`, `stall`, `mem_req` and `dev_req` are low, `value` is zero, and every register reads as zero.
- R2: A source byte with bit 7 clear is a device read. `dev_addr` equals bits 6:0 of the byte, and `value` is the `dev_rdata` present at the acknowledge edge.
- R3: A byte of the form 10xxxxxx yields bits 5:0 sign-extended to 16 bits (range -32 to +31). `done` is high in the second cycle after the cycle in which `start` was sampled.
- R4: A byte of the form 1100rrrr yields register r and leaves it unchanged.
- R5: A byte of the form 1101rrrr yields register r's value before the update. Afterwards register r holds that value plus one, modulo 2^16.
- R6: A byte of the form 1110rrrr yields the memory word whose address is register r, and leaves register r unchanged.
- R7: A byte of the form 1111rrrr yields the memory word at register r, then increments register r modulo 2^16.
- R8: A memory or device read holds its request with a stable address, and keeps `stall` high and `done` low, until acknowledge. `done` rises one cycle after the acknowledge edge. The addressing register is not updated before that edge.
- R9: `start` while an operation is in progress is ignored. The running operation's result is unaffected, and no second `done` follows.
- R10: `rf_wr_en` writes `rf_wr_data` into register `rf_wr_idx`. If it targets the register being post-incremented in the same cycle, the increment result is kept. A write to another register in that cycle takes effect alongside the increment.
- R11: `mem_req` and `dev_req` are never high together, and neither is high while `stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding `src_sel` (accepted only when idle) |
| src_sel | input | 8 | Source byte |
| value | output | 16 | Resolved operand, valid while `done` is high |
| done | output | 1 | One-cycle completion pulse |
| stall | output | 1 | Operation in progress |
| rf_wr_en | input | 1 | External register write enable |
| rf_wr_idx | input | 4 | External write register index |
| rf_wr_data | input | 16 | External write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data |
| mem_ack | input | 1 | Memory acknowledge |
| dev_req | output | 1 | Device read request |
| dev_addr | output | 7 | Device address |
| dev_rdata | input | 16 | Device read data |
| dev_ack | input | 1 | Device acknowledge |

## Verification
Assertions inside the RTL check several properties every cycle. Bus requests are mutually exclusive and never raised when idle. A pending request holds its address while it waits, and the addressing register does not move during a stall. `done` is a single-cycle pulse that follows an active operation, and an increment beats a same-cycle external write. The bench sweeps all 256 source bytes and varies the acknowledge latency. Only that sweep shows the actual operand values, sign extension, the pre-increment return value, the wrap from 0xFFFF to zero, and the rejection of a `start` raised mid-stall.

// File: rtl/mvsrc_pkg.sv
package mvsrc_pkg;
  typedef enum logic [1:0] {
    SRC_DEV = 2'd0,
    SRC_IMM = 2'd1,
    SRC_REG = 2'd2,
    SRC_MEM = 2'd3
  } src_kind_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } seq_state_e;

  localparam int SEL_W   = 8;
  localparam int IMM_W   = 6;
  localparam int DEVA_W  = 7;
  localparam int FIELD_W = 4;
endpackage

// File: rtl/mvsrc_decode.sv
module mvsrc_decode
  import mvsrc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [SEL_W-1:0]   sel,
  output src_kind_e          kind,
  output logic               post_inc,
  output logic [FIELD_W-1:0] reg_idx,
  output logic [DEVA_W-1:0]  dev_field,
  output logic [DW-1:0]      imm_value
);
  function automatic logic [DW-1:0] widen_signed(input logic [IMM_W-1:0] f);
    logic [DW-1:0] r;
    for (int b = 0; b < DW; b++) r[b] = (b < IMM_W) ? f[b] : f[IMM_W-1];
    return r;
  endfunction

  always_comb begin
    reg_idx   = sel[FIELD_W-1:0];
    dev_field = sel[DEVA_W-1:0];
    imm_value = widen_signed(sel[IMM_W-1:0]);
    post_inc  = 1'b0;
    if (!sel[7]) begin
      kind = SRC_DEV;
    end else if (!sel[6]) begin
      kind = SRC_IMM;
    end else if (!sel[5]) begin
      kind     = SRC_REG;
      post_inc = sel[4];
    end else begin
      kind     = SRC_MEM;
      post_inc = sel[4];
    end
  end
endmodule

// File: rtl/mvsrc_regfile.sv
module mvsrc_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          inc_we,
  input  logic [IW-1:0] inc_idx,
  input  logic [DW-1:0] inc_data,
  input  logic          ext_we,
  input  logic [IW-1:0] ext_idx,
  input  logic [DW-1:0] ext_data
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit_inc, hit_ext;
    assign hit_inc = inc_we && (inc_idx == IW'(g));
    assign hit_ext = ext_we && (ext_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)       regs[g] <= '0;
      else if (hit_inc) regs[g] <= inc_data;
      else if (hit_ext) regs[g] <= ext_data;
    end
  end

  assign rd_data = regs[rd_idx];

  // R10: increment result survives a same-index external write
  a_r10_inc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_we && ext_we && inc_idx == ext_idx) |=> regs[$past(inc_idx)] == $past(inc_data));
  // R10: a lone external write lands
  a_r10_ext_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_we && !(inc_we && inc_idx == ext_idx)) |=> regs[$past(ext_idx)] == $past(ext_data));
endmodule

// File: rtl/mvsrc_seq.sv
module mvsrc_seq
  import mvsrc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  src_kind_e kind,
  input  logic      mem_ack,
  input  logic      dev_ack,
  output logic      accept,
  output logic      run,
  output logic      finish
);
  seq_state_e st_q;

  assign run    = (st_q == SQ_RUN);
  assign accept = (st_q == SQ_IDLE) && start;

  always_comb begin
    finish = 1'b0;
    if (run) begin
      case (kind)
        SRC_MEM: finish = mem_ack;
        SRC_DEV: finish = dev_ack;
        default: finish = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      st_q <= SQ_IDLE;
    else if (accept) st_q <= SQ_RUN;
    else if (finish) st_q <= SQ_IDLE;
  end

  // R9: a start during an unfinished operation does not end or restart it
  a_r9_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && !finish) |=> run);
  // R8: bus kinds cannot complete without an acknowledge
  a_r8_no_ack_no_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (run && kind == SRC_MEM && !mem_ack) |-> !finish);
endmodule

// File: rtl/mv_src_unit.sv
module mv_src_unit
  import mvsrc_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    src_sel,
  output logic [DW-1:0] value,
  output logic          done,
  output logic          stall,
  input  logic          rf_wr_en,
  input  logic [3:0]    rf_wr_idx,
  input  logic [DW-1:0] rf_wr_data,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          dev_req,
  output logic [6:0]    dev_addr,
  input  logic [DW-1:0] dev_rdata,
  input  logic          dev_ack
);
  localparam int IW = $clog2(NREG);

  function automatic logic [DW-1:0] bump(input logic [DW-1:0] x);
    return x + DW'(1);
  endfunction

  logic [SEL_W-1:0]   sel_q;
  src_kind_e          kind;
  logic               post_inc;
  logic [FIELD_W-1:0] reg_idx;
  logic [DEVA_W-1:0]  dev_field;
  logic [DW-1:0]      imm_value;
  logic               accept, run, finish;
  logic [DW-1:0]      rd_data;
  logic               wb_fire;
  logic [DW-1:0]      result;
  logic [DW-1:0]      value_q;
  logic               done_q;

  mvsrc_decode #(.DW(DW)) u_dec (
    .sel(sel_q), .kind(kind), .post_inc(post_inc), .reg_idx(reg_idx),
    .dev_field(dev_field), .imm_value(imm_value)
  );

  mvsrc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind),
    .mem_ack(mem_ack), .dev_ack(dev_ack),
    .accept(accept), .run(run), .finish(finish)
  );

  assign wb_fire = finish && post_inc;

  mvsrc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(IW'(reg_idx)), .rd_data(rd_data),
    .inc_we(wb_fire), .inc_idx(IW'(reg_idx)), .inc_data(bump(rd_data)),
    .ext_we(rf_wr_en), .ext_idx(IW'(rf_wr_idx)), .ext_data(rf_wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= '0;
    else if (accept) sel_q <= src_sel;
  end

  always_comb begin
    case (kind)
      SRC_DEV: result = dev_rdata;
      SRC_IMM: result = imm_value;
      SRC_REG: result = rd_data;
      default: result = mem_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) value_q <= result;
    end
  end

  assign value    = value_q;
  assign done     = done_q;
  assign stall    = run;
  assign mem_req  = run && (kind == SRC_MEM);
  assign mem_addr = rd_data;
  assign dev_req  = run && (kind == SRC_DEV);
  assign dev_addr = dev_field;

  // R11: one bus at a time, only while active
  a_r11_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && dev_req));
  a_r11_req_needs_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || dev_req) |-> stall);
  // R8: waiting requests hold their address
  a_r8_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  a_r8_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && !dev_ack) |=> (dev_req && $stable(dev_addr)));
  // R8: addressing register unchanged while a memory load waits
  a_r8_reg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !rf_wr_en) |=> $stable(rd_data));
  // R3: done is a single pulse that follows an active cycle
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(run));
endmodule

// File: tb/mv_src_unit_tb_top.sv
module mv_src_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  src_sel = '0;
  logic [15:0] value;
  logic        done, stall;
  logic        rf_wr_en = 1'b0;
  logic [3:0]  rf_wr_idx = '0;
  logic [15:0] rf_wr_data = '0;
  logic        mem_req, dev_req;
  logic [15:0] mem_addr, mem_rdata, dev_rdata;
  logic [6:0]  dev_addr;
  logic        mem_ack = 1'b0, dev_ack = 1'b0;

  int n_chk = 0, n_fail = 0;
  int ack_dly = 0, ack_cnt = 0;
  logic [15:0] model [16];

  always #2 clk = ~clk;

  mv_src_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .src_sel(src_sel),
    .value(value), .done(done), .stall(stall),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .dev_req(dev_req), .dev_addr(dev_addr), .dev_rdata(dev_rdata), .dev_ack(dev_ack)
  );

  // Bus models: data is a fixed function of the address
  assign mem_rdata = mem_addr ^ 16'hA5C3;
  assign dev_rdata = {dev_addr, dev_addr, 2'b01};

  initial begin : responder
    forever begin
      @(negedge clk);
      if ((mem_req && !mem_ack) || (dev_req && !dev_ack)) begin
        if (ack_cnt >= ack_dly) begin
          mem_ack = mem_req; dev_ack = dev_req; ack_cnt = 0;
        end else ack_cnt++;
      end else begin
        mem_ack = 1'b0; dev_ack = 1'b0; ack_cnt = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_val(input logic [7:0] s);
    if (!s[7]) return {s[6:0], s[6:0], 2'b01};
    if (!s[6]) return {{10{s[5]}}, s[5:0]};
    if (!s[5]) return model[s[3:0]];
    return model[s[3:0]] ^ 16'hA5C3;
  endfunction

  function automatic string req_of(input logic [7:0] s);
    if (!s[7]) return "R2";
    if (!s[6]) return "R3";
    if (!s[5]) return s[4] ? "R5" : "R4";
    return s[4] ? "R7" : "R6";
  endfunction

  task automatic ext_write(input logic [3:0] i, input logic [15:0] d);
    @(negedge clk);
    rf_wr_en = 1'b1; rf_wr_idx = i; rf_wr_data = d;
    @(negedge clk);
    rf_wr_en = 1'b0;
    model[i] = d;
  endtask

  // Issue one operation; optionally poke start mid-flight or write a register
  task automatic run_op(input logic [7:0] s, input int dly, input bit poke,
                        input bit wen, input logic [3:0] widx, input logic [15:0] wdat);
    logic [15:0] exp, old;
    int cyc;
    bit bus;
    exp = expect_val(s);
    old = model[s[3:0]];
    bus = !s[7] || (s[7:5] == 3'b111);
    ack_dly = dly;
    @(negedge clk);
    start = 1'b1; src_sel = s;
    @(negedge clk);
    cyc = 1;
    start = poke; src_sel = 8'hC0 | ~s[3:0];
    rf_wr_en = wen; rf_wr_idx = widx; rf_wr_data = wdat;
    if (bus) chk(stall && (mem_req != dev_req), "R8", {15'd0, stall}, 16'd1);
    if (!s[7]) chk(dev_addr == s[6:0], "R2", {9'd0, dev_addr}, {9'd0, s[6:0]});
    while (!done && cyc < 20) begin
      @(negedge clk);
      start = 1'b0; rf_wr_en = 1'b0;
      cyc++;
    end
    start = 1'b0; rf_wr_en = 1'b0;
    chk(value == exp, req_of(s), value, exp);
    chk(cyc == (bus ? 2 + dly : 2), "R8", 16'(cyc), 16'(bus ? 2 + dly : 2));
    if (wen) model[widx] = wdat;
    if (s[7:6] == 2'b11 && s[4]) model[s[3:0]] = old + 16'd1;
    if (poke) begin
      @(negedge clk);
      chk(!done && !stall, "R9", {14'd0, done, stall}, 16'd0);
    end
  endtask

  task automatic read_back(input logic [3:0] r, input string req);
    logic [15:0] e;
    e = model[r];
    run_op(8'hC0 | r, 0, 1'b0, 1'b0, 4'd0, 16'd0);
    chk(value == e, req, value, e);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!done && !stall && !mem_req && !dev_req, "R1", {12'd0, done, stall, mem_req, dev_req}, 16'd0);
    chk(value == 16'd0, "R1", value, 16'd0);
    for (int i = 0; i < 16; i++) read_back(4'(i), "R1");

    // R10 load registers, including an all-ones register for the wrap case
    for (int i = 0; i < 16; i++) ext_write(4'(i), 16'(i * 16'h1357 + 16'h0101));
    ext_write(4'd5, 16'hFFFF);
    for (int i = 0; i < 16; i++) read_back(4'(i), "R10");

    // Exhaustive sweep of the source byte, varying ack latency
    for (int s = 0; s < 256; s++) begin
      run_op(8'(s), s % 4, (s % 4) == 3, 1'b0, 4'd0, 16'd0);
      if (s >= 8'hC0) read_back(4'(s), (s[4]) ? "R5" : "R4");
    end
    // R5 wrap: register 5 started at FFFF and was incremented twice in the sweep
    chk(model[5] == 16'd1, "R5", model[5], 16'd1);
    read_back(4'd5, "R5");

    // R10 collision: write to the register being incremented; increment wins
    run_op(8'hD3, 0, 1'b0, 1'b1, 4'd3, 16'h7777);
    read_back(4'd3, "R10");
    // R10 write to a different register in the same cycle
    run_op(8'hD4, 0, 1'b0, 1'b1, 4'd6, 16'h4242);
    read_back(4'd4, "R10");
    read_back(4'd6, "R10");

    // R9 mid-stall start ignored on a device and a memory read
    run_op(8'h15, 3, 1'b1, 1'b0, 4'd0, 16'd0);
    run_op(8'hF2, 3, 1'b1, 1'b0, 4'd0, 16'd0);
    read_back(4'd2, "R7");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule